// File: doc/BRIEF.md
# Programmable Memory Chip-Select Generator

This block turns a processor address into two active-low memory selects. The high select serves boot memory. Its window always ends at the last address of the space. The low select serves working memory. Its window always starts at address zero. Each window's size is a power of two, set by a 3-bit code. Code k gives a window of 2^(10+k) bytes, so the sizes run from 1 KB to 128 KB.

Out of reset the high window is the top 1 KB, which holds the reset vector, and the low select is switched off. Boot code must first widen the high window to the size of the real boot memory. It must then enable the low window before it uses any stack or variables. Both selects assert only while the bus-cycle strobe is high.

Top module: `memcs_gen`

## Requirements
- R1: After reset the high select asserts for addresses 0xFFC00 through 0xFFFFF and does not assert for 0xFFBFF.
- R2: After reset the reset-vector address 0xFFFF0 asserts the high select, with no register written.
- R3: With high size code k, the high select asserts exactly for addresses at or above 2^ADDR_W − 2^(10+k). For example, code 5 selects 0xF8000 but not 0xF7FFF.
- R4: With the low select enabled and low size code k, the low select asserts exactly for addresses 0 through 2^(10+k) − 1.
- R5: The low select stays deasserted after reset until a write sets its enable bit. A write with the enable bit at 0 leaves it deasserted.
- R6: Both selects are active low. Both are high (inactive) whenever the cycle strobe is low or reset is high.
- R7: A register write uses the write enable, a select bit and a 4-bit data field. Select bit 0 chooses the high window and 1 the low window. Data bits [2:0] carry the size code and data bit 3 is the low-window enable, which the high window ignores. The write takes effect at the next rising clock edge. With the write enable low, the configuration does not change. Reset wins over a write in the same cycle.
- R8: Where the two windows overlap, the high select asserts and the low select is held high. The two selects are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | Bus-cycle strobe qualifying the address |
| addr | input | ADDR_W | Processor address |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | Register choice: 0 high window, 1 low window |
| cfg_data | input | 4 | [2:0] size code, [3] low-window enable |
| hi_cs_n | output | 1 | Active-low high (boot) memory select |
| lo_cs_n | output | 1 | Active-low low (work) memory select |

## Verification
Two functions can fall in the same cycle: a register write, and a decode that uses the configuration the write is about to replace. The bench drives a write while an address at the old or new window edge is on the bus. It expects the old decode in that cycle and the new decode in the next one.

The second collision is overlap between the two windows. A second instance with a 17-bit address space lets both windows cover everything. For each case, a behavioural model that holds the configuration as integers judges every clock.

// File: rtl/memcs_pkg.sv
package memcs_pkg;
  localparam int CODE_W  = 3;
  localparam int DATA_W  = CODE_W + 1;
  localparam int MAX_CODE = (1 << CODE_W) - 1;

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] code;
  } win_cfg_t;
endpackage

// File: rtl/memcs_cfg_regs.sv
module memcs_cfg_regs
  import memcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              sel,
  input  logic [DATA_W-1:0] data,
  output win_cfg_t          hi_cfg,
  output win_cfg_t          lo_cfg
);
  // High window: always enabled, boots to the smallest size.
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cfg.en   <= 1'b1;
      hi_cfg.code <= '0;
    end else if (we && !sel) begin
      hi_cfg.en   <= 1'b1;
      hi_cfg.code <= data[CODE_W-1:0];
    end
  end

  // Low window: disabled until software sets the enable bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cfg.en   <= 1'b0;
      lo_cfg.code <= '0;
    end else if (we && sel) begin
      lo_cfg.en   <= data[CODE_W];
      lo_cfg.code <= data[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/memcs_win_dec.sv
module memcs_win_dec
  import memcs_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int MIN_WIN_LOG2 = 10,
  parameter bit ANCHOR_TOP   = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  win_cfg_t          cfg,
  output logic              hit
);
  // keep[i] marks address bits above the window's offset field.
  logic [ADDR_W-1:0] keep;

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) begin
      keep[i] = (i >= MIN_WIN_LOG2 + int'(cfg.code));
    end
  end

  generate
    if (ANCHOR_TOP) begin : g_top
      // Window ends at the top: every kept bit must be one.
      assign hit = cfg.en & (&(addr | ~keep));
    end else begin : g_zero
      // Window starts at zero: every kept bit must be zero.
      assign hit = cfg.en & ~(|(addr & keep));
    end
  endgenerate
endmodule

// File: rtl/memcs_gen.sv
module memcs_gen
  import memcs_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int MIN_WIN_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [3:0]        cfg_data,
  output logic              hi_cs_n,
  output logic              lo_cs_n
);
  win_cfg_t hi_cfg, lo_cfg;
  logic     hi_hit, lo_hit;
  logic     qual;

  memcs_cfg_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .sel    (cfg_sel),
    .data   (cfg_data),
    .hi_cfg (hi_cfg),
    .lo_cfg (lo_cfg)
  );

  memcs_win_dec #(
    .ADDR_W       (ADDR_W),
    .MIN_WIN_LOG2 (MIN_WIN_LOG2),
    .ANCHOR_TOP   (1'b1)
  ) u_hi_dec (
    .addr (addr),
    .cfg  (hi_cfg),
    .hit  (hi_hit)
  );

  memcs_win_dec #(
    .ADDR_W       (ADDR_W),
    .MIN_WIN_LOG2 (MIN_WIN_LOG2),
    .ANCHOR_TOP   (1'b0)
  ) u_lo_dec (
    .addr (addr),
    .cfg  (lo_cfg),
    .hit  (lo_hit)
  );

  assign qual = cyc_valid & ~rst;

  // High window wins an overlap.
  always_comb begin
    hi_cs_n = ~(qual & hi_hit);
    lo_cs_n = ~(qual & lo_hit & ~hi_hit);
  end
endmodule

// File: rtl/memcs_gen_chk.sv
module memcs_gen_chk #(
  parameter int ADDR_W       = 20,
  parameter int MIN_WIN_LOG2 = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc_valid,
  input logic [ADDR_W-1:0] addr,
  input logic              cfg_we,
  input logic              cfg_sel,
  input logic [3:0]        cfg_data,
  input logic              hi_cs_n,
  input logic              lo_cs_n
);
  localparam bool_hi_bounded = (ADDR_W > MIN_WIN_LOG2 + memcs_pkg::MAX_CODE);

  // R6: strobe low keeps both selects inactive.
  a_r6_idle_high: assert property (@(posedge clk) disable iff (rst)
    !cyc_valid |-> (hi_cs_n && lo_cs_n));

  // R8: never both selects active.
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!hi_cs_n && !lo_cs_n));

  // R1/R2: the top 1 KB lies inside every high window size.
  a_r1_top_always_hi: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && (&addr[ADDR_W-1:MIN_WIN_LOG2])) |-> !hi_cs_n);

  // R5: first cycle after reset has the low window off.
  a_r5_lo_off_after_rst: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> lo_cs_n);

  // R3: lower half of a large space is never in the high window.
  a_r3_hi_bounded: assert property (@(posedge clk) disable iff (rst)
    (bool_hi_bounded && cyc_valid && !addr[ADDR_W-1]) |-> hi_cs_n);

  // R7: without a write, same inputs give same selects.
  a_r7_hold_no_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfg_we) && !$past(rst) && $stable(addr) && $stable(cyc_valid))
      |-> ($stable(hi_cs_n) && $stable(lo_cs_n)));

  // cfg_sel/cfg_data feed no property here; bench checks their decode.
  logic unused_ok;
  assign unused_ok = ^{cfg_sel, cfg_data};
endmodule

bind memcs_gen memcs_gen_chk #(
  .ADDR_W       (ADDR_W),
  .MIN_WIN_LOG2 (MIN_WIN_LOG2)
) u_chk (.*);

// File: tb/memcs_gen_tb.sv
module memcs_gen_tb;
  localparam int AW  = 20;
  localparam int AWS = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_valid = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [AWS-1:0] addr_s;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [3:0]  cfg_data = '0;
  logic        hi_cs_n, lo_cs_n, hi_cs_n_s, lo_cs_n_s;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // model state, one per instance
  int m_hc[2], m_lc[2];
  bit m_le[2];

  always #4 clk = ~clk;   // 125 MHz
  assign addr_s = addr[AWS-1:0];

  memcs_gen #(.ADDR_W(AW), .MIN_WIN_LOG2(10)) u_dut (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .addr(addr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .hi_cs_n(hi_cs_n), .lo_cs_n(lo_cs_n));

  memcs_gen #(.ADDR_W(AWS), .MIN_WIN_LOG2(10)) u_dut_small (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .addr(addr_s),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .hi_cs_n(hi_cs_n_s), .lo_cs_n(lo_cs_n_s));

  function automatic logic [1:0] ref_cs(int aw, int a, bit v, bit r,
                                         int hc, int lc, bit le);
    int  top = 1 << aw;
    int  am  = a & (top - 1);
    bit  up  = am >= top - (1 << (10 + hc));
    bit  lo  = le && (am < (1 << (10 + lc))) && !up;
    if (r || !v) return 2'b11;
    return {~up, ~lo};
  endfunction

  task automatic compare(string tag, int idx, int aw, logic [1:0] act, int a);
    logic [1:0] exp = ref_cs(aw, a, cyc_valid, rst, m_hc[idx], m_lc[idx], m_le[idx]);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s inst=%0d addr=%h actual hi/lo=%b expected hi/lo=%b",
               tag, idx, a, act, exp);
    end
  endtask

  task automatic step(string tag, bit r, bit v, int a, bit we, bit sel, int d);
    rst = r; cyc_valid = v; addr = a[AW-1:0];
    cfg_we = we; cfg_sel = sel; cfg_data = d[3:0];
    #2;
    compare(tag, 0, AW,  {hi_cs_n, lo_cs_n}, a);
    compare(tag, 1, AWS, {hi_cs_n_s, lo_cs_n_s}, a);
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      if (r) begin m_hc[k] = 0; m_lc[k] = 0; m_le[k] = 0; end
      else if (we) begin
        if (sel) begin m_lc[k] = d & 7; m_le[k] = d[3]; end
        else m_hc[k] = d & 7;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin m_hc[k] = 0; m_lc[k] = 0; m_le[k] = 0; end
    @(negedge clk);
    // R6: reset holds selects high; R7: write during reset is lost
    step("R6", 1, 1, 'hFFFF0, 0, 0, 0);
    step("R6", 1, 1, 'h00000, 1, 1, 'hF);
    step("R7", 1, 1, 'h00000, 1, 0, 'h7);
    // R2 / R1 reset window
    step("R2", 0, 1, 'hFFFF0, 0, 0, 0);
    step("R1", 0, 1, 'hFFC00, 0, 0, 0);
    step("R1", 0, 1, 'hFFFFF, 0, 0, 0);
    step("R1", 0, 1, 'hFFBFF, 0, 0, 0);
    // R5 low off after reset
    step("R5", 0, 1, 'h00000, 0, 0, 0);
    step("R5", 0, 1, 'h00100, 0, 0, 0);
    // R6 strobe low
    step("R6", 0, 0, 'hFFFF0, 0, 0, 0);
    // R7/R3: widen high to 32 KB; same-cycle decode uses old size
    step("R7", 0, 1, 'hF8000, 1, 0, 5);
    step("R3", 0, 1, 'hF8000, 0, 0, 0);
    step("R3", 0, 1, 'hF7FFF, 0, 0, 0);
    // R5: size written with enable clear stays off
    step("R5", 0, 1, 'h00000, 1, 1, 'h2);
    step("R5", 0, 1, 'h00000, 0, 0, 0);
    // R4: enable 4 KB low window
    step("R4", 0, 1, 'h00000, 1, 1, 'hA);
    step("R4", 0, 1, 'h00000, 0, 0, 0);
    step("R4", 0, 1, 'h00FFF, 0, 0, 0);
    step("R4", 0, 1, 'h01000, 0, 0, 0);
    // R7: no write enable, no change
    step("R7", 0, 1, 'h00FFF, 0, 1, 'h0);
    step("R7", 0, 1, 'h00FFF, 0, 0, 'h0);
    step("R7", 0, 1, 'hF8000, 0, 0, 0);
    // R3/R4 sweep every size pair at window edges
    for (int hc = 0; hc < 8; hc++) begin
      for (int lc = 0; lc < 8; lc++) begin
        int hb = (1 << AW) - (1 << (10 + hc));
        int ll = (1 << (10 + lc));
        step("R7", 0, 1, hb, 1, 0, hc);
        step("R7", 0, 1, ll, 1, 1, 8 + lc);
        step("R3", 0, 1, hb - 1, 0, 0, 0);
        step("R3", 0, 1, hb, 0, 0, 0);
        step("R3", 0, 1, (1 << AW) - 1, 0, 0, 0);
        step("R4", 0, 1, 0, 0, 0, 0);
        step("R4", 0, 1, ll - 1, 0, 0, 0);
        step("R4", 0, 1, ll, 0, 0, 0);
      end
    end
    // R8: small instance, both windows full size overlap everywhere
    step("R8", 0, 1, 0, 1, 0, 7);
    step("R8", 0, 1, 0, 1, 1, 'hF);
    step("R8", 0, 1, 'h00000, 0, 0, 0);
    step("R8", 0, 1, 'h1FFFF, 0, 0, 0);
    step("R8", 0, 1, 'h0FFFF, 0, 0, 0);
    step("R8", 0, 1, 'h00000, 1, 0, 6);
    step("R8", 0, 1, 'h0FFFF, 0, 0, 0);
    step("R8", 0, 1, 'h10000, 0, 0, 0);
    // mixed random traffic including writes and reset pulses
    for (int n = 0; n < 3000; n++) begin
      int  rv = $urandom;
      bit  r  = (rv % 97) == 0;
      bit  we = (rv[7:4] == 0);
      step("R7", r, rv[8], int'($urandom) & ((1 << AW) - 1), we, rv[9], rv[13:10]);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule